// File: doc/BRIEF.md
# Endian-Swapping I/O Window Bridge

The bridge sits between a processor-side request bus and a little-endian, port-style I/O bus. It watches every processor request for an address inside a fixed 64 KB window that starts at physical address 0x1400_0000. A request that falls inside the window and carries a supported size becomes one I/O transaction. That transaction carries the low 16 address bits as the port number, together with the access size, the direction and the write data. Any other request completes at once with a miss indication and never reaches the I/O bus.

A compile-time parameter selects whether the processor side is big-endian. When it is big-endian, halfword data has its two bytes exchanged and word data has its four bytes reversed, on both the write path and the read path. Byte data always passes unchanged. The bridge holds a forwarded request on the I/O bus until the I/O side acknowledges it. It then reports completion with a one-cycle response pulse, and that pulse carries the read data for reads.

Top module: `io_window_bridge`

## Requirements
- R1: A request accepted with an address from 0x1400_0000 to 0x1400_FFFF and a supported size raises `io_valid_o` in the next cycle.
- R2: While `io_valid_o` is high, `io_addr_o` equals the low 16 bits of the accepted address, and `io_size_o` and `io_write_o` equal the accepted size and direction.
- R3: A request whose address is outside the window, or whose size code is 3, starts no I/O transaction. In the next cycle it gives `rsp_valid_o` and `rsp_miss_o` high with `rsp_rdata_o` zero.
- R4: A pending I/O request keeps its address, size, direction and write data stable until `io_ack_i`, and `req_ready_o` stays low for as long as it is pending.
- R5: In the cycle after `io_valid_o` and `io_ack_i` are both high, `rsp_valid_o` is high for one cycle with `rsp_miss_o` low, and `io_valid_o` is low.
- R6: Size code 0 selects a byte, carried in bits 7:0 and never swapped. On both paths, bytes beyond the access size are driven to zero.
- R7: With the big-endian parameter set, size code 1 (halfword, bits 15:0) exchanges bits 15:8 and 7:0 on both write and read.
- R8: With the big-endian parameter set, size code 2 (word) reverses the four bytes on both write and read.
- R9: With the big-endian parameter clear, halfword and word data pass in their original byte order.
- R10: `rsp_rdata_o` is zero in every cycle that is not a read response.
- R11: During and right after reset, `req_ready_o` is high and `io_valid_o`, `rsp_valid_o` and `rsp_miss_o` are low.
- R12: A new request can be accepted in the same cycle as a response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Bridge can accept a request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Processor physical address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| req_wdata_i | input | 32 | Write data, processor byte order, low lanes |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_miss_o | output | 1 | Completion was a window miss |
| rsp_rdata_o | output | 32 | Read data, processor byte order |
| io_valid_o | output | 1 | I/O transaction pending |
| io_ack_i | input | 1 | I/O side completes the pending transaction |
| io_write_o | output | 1 | I/O direction |
| io_addr_o | output | 16 | Port address |
| io_size_o | output | 2 | I/O access size |
| io_wdata_o | output | 32 | Write data, little-endian lanes |
| io_rdata_i | input | 32 | Read data, little-endian lanes, taken with the acknowledge |

## Verification
A response pulse and the acceptance of the next request can happen in the same cycle. Because the bridge returns to idle as the pulse is raised, the pulse and the new acceptance coincide. The bench provokes this by watching for the pulse of a forwarded read and, in that same cycle, presenting a second request (a miss). It judges the result by checking that ready was high during the pulse and that the second response follows on the next cycle with the right miss state. A cycle-by-cycle reference model compares every output of a big-endian and a little-endian instance, which share the same stimulus, on every clock, with random read data driven between acknowledges.

// File: rtl/iob_pkg.sv
package iob_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } iob_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } iob_state_e;
endpackage

// File: rtl/iob_win_decode.sv
module iob_win_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_AW   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1400_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic [WIN_AW-1:0] port_o
);
  import iob_pkg::*;
  localparam int unsigned TAG_W = ADDR_W - WIN_AW;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_AW];

  logic tag_match;
  logic size_ok;

  assign tag_match = (addr_i[ADDR_W-1:WIN_AW] == BASE_TAG);
  assign size_ok   = (size_i != SZ_RSVD);
  assign hit_o     = tag_match && size_ok;
  assign port_o    = addr_i[WIN_AW-1:0];
endmodule

// File: rtl/iob_lane_swap.sv
module iob_lane_swap #(
  parameter int unsigned DATA_W     = 32,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  import iob_pkg::*;
  localparam int unsigned NB = DATA_W / 8;

  int lanes;
  always_comb begin
    case (size_i)
      SZ_BYTE: lanes = 1;
      SZ_HALF: lanes = 2;
      SZ_WORD: lanes = 4;
      default: lanes = 0;
    endcase
  end

  generate
    if (BIG_ENDIAN) begin : g_swap
      always_comb begin
        data_o = '0;
        for (int i = 0; i < NB; i++) begin
          if (i < lanes) data_o[i*8 +: 8] = data_i[(lanes-1-i)*8 +: 8];
        end
      end
    end else begin : g_pass
      always_comb begin
        data_o = '0;
        for (int i = 0; i < NB; i++) begin
          if (i < lanes) data_o[i*8 +: 8] = data_i[i*8 +: 8];
        end
      end
    end
  endgenerate

  // R6: a single byte keeps its lane whatever the endianness
  always_comb begin
    if (size_i == SZ_BYTE) begin
      assert_byte_pass_R6: assert (data_o == {{(DATA_W-8){1'b0}}, data_i[7:0]});
    end
  end
endmodule

// File: rtl/iob_ctrl.sv
module iob_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              hit_i,
  input  logic              write_i,
  input  logic [WIN_AW-1:0] port_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              io_valid_o,
  input  logic              io_ack_i,
  output logic              io_write_o,
  output logic [WIN_AW-1:0] io_addr_o,
  output logic [1:0]        io_size_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_miss_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  import iob_pkg::*;

  iob_state_e state_q;
  logic accept;
  logic done;

  assign req_ready_o = (state_q == ST_IDLE);
  assign io_valid_o  = (state_q == ST_WAIT);
  assign accept      = req_valid_i && req_ready_o;
  assign done        = io_valid_o && io_ack_i;

  // R11: reset leaves the bridge idle with no response pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      io_write_o  <= 1'b0;
      io_addr_o   <= '0;
      io_size_o   <= SZ_BYTE;
      io_wdata_o  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_rdata_o <= '0;
      if (accept) begin
        if (hit_i) begin
          state_q    <= ST_WAIT;
          io_write_o <= write_i;
          io_addr_o  <= port_i;
          io_size_o  <= size_i;
          io_wdata_o <= write_i ? wdata_i : '0;
        end else begin
          rsp_valid_o <= 1'b1;
          rsp_miss_o  <= 1'b1;
        end
      end else if (done) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_rdata_o <= io_write_o ? '0 : rdata_i;
      end
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_o && !io_ack_i) |=> (io_valid_o && !req_ready_o && $stable(io_addr_o)
      && $stable(io_size_o) && $stable(io_write_o) && $stable(io_wdata_o)));

  assert_rsp_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_o && io_ack_i) |=> (rsp_valid_o && !rsp_miss_o && !io_valid_o));

  assert_miss_no_io_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !hit_i) |=>
      (!io_valid_o && rsp_valid_o && rsp_miss_o && rsp_rdata_o == '0));

  assert_quiet_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsp_valid_o || rsp_miss_o) |-> (rsp_rdata_o == '0));
endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WIN_AW     = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h1400_0000,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_miss_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              io_valid_o,
  input  logic              io_ack_i,
  output logic              io_write_o,
  output logic [WIN_AW-1:0] io_addr_o,
  output logic [1:0]        io_size_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic [DATA_W-1:0] io_rdata_i
);
  logic              hit;
  logic [WIN_AW-1:0] port;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rdata_sw;

  iob_win_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i), .hit_o(hit), .port_o(port)
  );

  iob_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
    .size_i(req_size_i), .data_i(req_wdata_i), .data_o(wdata_sw)
  );

  // read data is reordered by the size of the transaction being held
  iob_lane_swap #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
    .size_i(io_size_o), .data_i(io_rdata_i), .data_o(rdata_sw)
  );

  iob_ctrl #(.DATA_W(DATA_W), .WIN_AW(WIN_AW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .hit_i(hit), .write_i(req_write_i), .port_i(port),
    .size_i(req_size_i), .wdata_i(wdata_sw),
    .io_valid_o(io_valid_o), .io_ack_i(io_ack_i), .io_write_o(io_write_o),
    .io_addr_o(io_addr_o), .io_size_o(io_size_o), .io_wdata_o(io_wdata_o),
    .rdata_i(rdata_sw),
    .rsp_valid_o(rsp_valid_o), .rsp_miss_o(rsp_miss_o), .rsp_rdata_o(rsp_rdata_o)
  );

  assert_fwd_R1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit) |=>
      (io_valid_o && io_addr_o == $past(req_addr_i[WIN_AW-1:0])
       && io_size_o == $past(req_size_i) && io_write_o == $past(req_write_i)));

  assert_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_size_i != 2'd3
     && req_addr_i[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]) |=> io_valid_o);
endmodule

// File: tb/io_window_bridge_tb_top.sv
module io_window_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = '0;

  logic        be_ready, be_rv, be_rm, be_iov, be_iow;
  logic [31:0] be_rd, be_iowd;
  logic [15:0] be_ioa;
  logic [1:0]  be_ios;
  logic        le_ready, le_rv, le_rm, le_iov, le_iow;
  logic [31:0] le_rd, le_iowd;
  logic [15:0] le_ioa;
  logic [1:0]  le_ios;

  io_window_bridge #(.BIG_ENDIAN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(be_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(be_rv), .rsp_miss_o(be_rm),
    .rsp_rdata_o(be_rd), .io_valid_o(be_iov), .io_ack_i(io_ack),
    .io_write_o(be_iow), .io_addr_o(be_ioa), .io_size_o(be_ios),
    .io_wdata_o(be_iowd), .io_rdata_i(io_rdata));

  io_window_bridge #(.BIG_ENDIAN(1'b0)) dut_le_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(le_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(le_rv), .rsp_miss_o(le_rm),
    .rsp_rdata_o(le_rd), .io_valid_o(le_iov), .io_ack_i(io_ack),
    .io_write_o(le_iow), .io_addr_o(le_ioa), .io_size_o(le_ios),
    .io_wdata_o(le_iowd), .io_rdata_i(io_rdata));

  int total = 0, bad = 0;
  bit done = 1'b0;
  int lat_next = 0;
  logic [31:0] rd_next = '0;

  function automatic logic [31:0] exp_lane(bit be, logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'd0: return {24'h0, d[7:0]};
      2'd1: return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      2'd2: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string dtag(bit be, logic [1:0] sz);
    if (sz == 2'd0) return "R6";
    if (!be) return "R9";
    return (sz == 2'd1) ? "R7" : "R8";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model, updated on each rising edge from the sampled inputs
  bit          m_busy = 0, m_write = 0, m_rsp = 0, m_miss = 0, m_isrd = 0;
  logic [15:0] m_addr = '0;
  logic [1:0]  m_size = '0;
  logic [31:0] m_wd = '0, m_rdraw = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rsp = 0; m_miss = 0; m_isrd = 0;
    end else if (!m_busy && req_valid) begin
      if (req_addr >= 32'h1400_0000 && req_addr <= 32'h1400_FFFF && req_size != 2'd3) begin
        m_busy = 1; m_write = req_write; m_addr = req_addr[15:0];
        m_size = req_size; m_wd = req_wdata; m_rsp = 0; m_miss = 0; m_isrd = 0;
      end else begin
        m_rsp = 1; m_miss = 1; m_isrd = 0;
      end
    end else if (m_busy && io_ack) begin
      m_busy = 0; m_rsp = 1; m_miss = 0; m_isrd = !m_write; m_rdraw = io_rdata;
    end else begin
      m_rsp = 0; m_miss = 0; m_isrd = 0;
    end
  end

  task automatic cmp_dut(bit be, logic rdy, logic iov, logic iow, logic [15:0] ioa,
                         logic [1:0] ios, logic [31:0] iowd, logic rv, logic rm,
                         logic [31:0] rd);
    string p = be ? "big " : "little ";
    chk("R4", {p, "req_ready"}, 32'(rdy), 32'(!m_busy));
    chk("R1", {p, "io_valid"}, 32'(iov), 32'(m_busy));
    if (m_busy) begin
      chk("R2", {p, "io_addr"}, 32'(ioa), 32'(m_addr));
      chk("R2", {p, "io_size"}, 32'(ios), 32'(m_size));
      chk("R2", {p, "io_write"}, 32'(iow), 32'(m_write));
      if (m_write) chk(dtag(be, m_size), {p, "io_wdata"}, iowd, exp_lane(be, m_size, m_wd));
    end
    chk("R5", {p, "rsp_valid"}, 32'(rv), 32'(m_rsp));
    chk("R3", {p, "rsp_miss"}, 32'(rm), 32'(m_rsp && m_miss));
    if (m_rsp && m_isrd)
      chk(dtag(be, m_size), {p, "rsp_rdata"}, rd, exp_lane(be, m_size, m_rdraw));
    else
      chk("R10", {p, "rsp_rdata"}, rd, 32'h0);
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      cmp_dut(1'b1, be_ready, be_iov, be_iow, be_ioa, be_ios, be_iowd, be_rv, be_rm, be_rd);
      cmp_dut(1'b0, le_ready, le_iov, le_iow, le_ioa, le_ios, le_iowd, le_rv, le_rm, le_rd);
    end
  end

  // I/O responder: acknowledges after lat_next waiting cycles, noise otherwise
  initial begin
    int rcnt = 0;
    forever begin
      @(negedge clk);
      if (io_ack) begin
        io_ack = 1'b0; rcnt = 0;
      end else if (rst_n && be_iov) begin
        if (rcnt >= lat_next) begin
          io_ack = 1'b1; io_rdata = rd_next;
        end else rcnt++;
      end
      if (!io_ack) io_rdata = $urandom;
    end
  end

  task automatic drive(bit w, logic [31:0] a, logic [1:0] s, logic [31:0] wd);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = wd;
  endtask

  task automatic do_req(bit w, logic [31:0] a, logic [1:0] s, logic [31:0] wd,
                        logic [31:0] rd, int lat);
    rd_next = rd; lat_next = lat;
    @(negedge clk);
    drive(w, a, s, wd);
    while (!be_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!be_rv) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "ready in reset", 32'(be_ready && le_ready), 32'h1);
    chk("R11", "idle outputs in reset", 32'({be_iov, be_rv, be_rm, le_iov, le_rv, le_rm}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", 32'(be_ready), 32'h1);
    chk("R11", "rsp after reset", 32'({be_rv, be_rm, be_iov}), 32'h0);

    // R6 R7 R8 R9 writes of each size, R2 port truncation
    do_req(1, 32'h1400_03F8, 2'd0, 32'hDEAD_BE5A, 32'h0, 0);
    do_req(1, 32'h1400_1234, 2'd1, 32'hFFFF_A1B2, 32'h0, 1);
    do_req(1, 32'h1400_0300, 2'd2, 32'h1122_3344, 32'h0, 2);
    // reads with junk in unused lanes
    do_req(0, 32'h1400_0010, 2'd0, 32'h0, 32'h7766_55C3, 0);
    do_req(0, 32'h1400_0020, 2'd1, 32'h0, 32'hEEEE_BEEF, 3);
    do_req(0, 32'h1400_0030, 2'd2, 32'h0, 32'hCAFE_F00D, 1);
    // window edges R1 and misses R3
    do_req(0, 32'h1400_0000, 2'd2, 32'h0, 32'h0102_0304, 0);
    do_req(0, 32'h1400_FFFF, 2'd0, 32'h0, 32'h0000_00AB, 0);
    do_req(0, 32'h13FF_FFFF, 2'd0, 32'h0, 32'h0, 0);
    do_req(1, 32'h1401_0000, 2'd2, 32'h5555_AAAA, 32'h0, 0);
    do_req(0, 32'h1400_0040, 2'd3, 32'h0, 32'h0, 0);
    chk("R3", "miss leaves io idle", 32'(be_iov || le_iov), 32'h0);

    // R12: next request offered during the response pulse
    rd_next = 32'h89AB_CDEF; lat_next = 2;
    @(negedge clk);
    drive(0, 32'h1400_0100, 2'd2, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!be_rv) @(negedge clk);
    chk("R12", "ready during response pulse", 32'(be_ready && le_ready), 32'h1);
    drive(0, 32'h2000_0000, 2'd1, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "second response follows", 32'({be_rv, be_rm}), 32'h3);

    for (int k = 0; k < 60; k++) begin
      logic [31:0] a;
      a = ($urandom_range(0, 5) == 0) ? $urandom : {16'h1400, 16'($urandom)};
      do_req(1'($urandom), a, 2'($urandom), $urandom, $urandom, $urandom_range(0, 3));
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule